// File: doc/BRIEF.md
# Double-Buffered Serial Byte Datapath for a Two-Wire Bus Controller

This block is the byte-level data path of a two-wire (I2C) bus controller. Software writes a byte into a transmit holding register. A hidden shift register puts that byte onto the data line one bit at a time. Incoming bits are collected in the same shift register, and each finished byte is parked in a receive holding register for software to read. An external bit-timing and protocol sequencer drives the block through two strobes. A shift strobe advances the outgoing bit, and a sample strobe captures the incoming bit. A direction input tells the block which of the two it is doing.

Because the transmit side has two stages, software can queue the next byte while the current one is still shifting out. The queued byte follows the current one with no idle strobe in between. A single control bit selects whether bytes move most- or least-significant bit first. That bit applies to transmit and receive alike. It also changes how the transmit holding register looks when read back. Two flags tell software when it may refill the transmit side and when a received byte is waiting. A third flag reports a received byte that was lost because software had not yet read the previous one.

Top module: `i2c_byte_path`

## Requirements
- R1: After reset, the transmit register (address 0) and the receive register (address 1) both read 0xFF. tx_empty is 1, rx_full is 0, rx_overrun is 0, and sda_out is 1.
- R2: A write to address 0 clears tx_empty at the next clock edge. If mode_rx is 0 and the shifter is idle, the byte moves into the shift register on the following edge, and tx_empty returns to 1 on that same edge.
- R3: While a byte is shifting out, sda_out presents its current bit, and each shift_strobe advances to the next bit. With control bit 0 at address 2 equal to 0 the order is most-significant bit first; with it equal to 1 the order is least-significant bit first.
- R4: A byte written to address 0 while another is shifting out is presented from the edge of that byte's eighth shift_strobe, with no idle strobe in between. With nothing queued, sda_out returns to 1 after the eighth strobe.
- R5: With mode_rx at 1, each sample_strobe captures sda_in. On the edge of the eighth sample the assembled byte appears at address 1 and rx_full becomes 1. In most-significant-bit-first order the first sampled bit lands in bit 7; in least-significant-bit-first order it lands in bit 0.
- R6: A read of address 1 (rd_en high) clears rx_full and rx_overrun at the next edge.
- R7: If a byte completes while rx_full is 1 and address 1 is not being read, rx_overrun becomes 1 and address 1 keeps the older byte.
- R8: Writes to address 1 have no effect on the receive register.
- R9: A read of address 0 returns the written byte when control bit 0 is 0, and the same byte bit-reversed (bit 0 swapped with bit 7, and so on) when control bit 0 is 1.
- R10: The shift register cannot be read: address 3 reads 0. Address 2 reads the bit-order control in bit 0 and zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears receive flags when address is 1) |
| addr | input | 2 | Register select: 0 transmit, 1 receive, 2 control, 3 hidden |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the selected address (combinational) |
| mode_rx | input | 1 | 0 = transmit direction, 1 = receive direction |
| shift_strobe | input | 1 | Advance the outgoing bit (transmit) |
| sample_strobe | input | 1 | Capture sda_in (receive) |
| sda_in | input | 1 | Incoming data line level |
| sda_out | output | 1 | Outgoing data line level, 1 when idle |
| tx_empty | output | 1 | Transmit holding register may be refilled |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| rx_overrun | output | 1 | A received byte was dropped while rx_full was set |

## Verification
The bench builds the block with the default byte width DW=8. With that width the 3-bit counter wraps after exactly eight strobes, so the reload on the last strobe and the capture on the last sample both land on the counter's terminal value. Asymmetric patterns such as 0xC5 and 0x1E make a bit-order error show up as a distinct value, both on the data line and in the reversed read-back. Queuing a second byte mid-transfer, and leaving a received byte unread while another arrives, reach the zero-gap reload and the overrun-keeps-old-byte paths.

// File: rtl/i2c_bp_pkg.sv
package i2c_bp_pkg;
  typedef enum logic [1:0] {
    REG_TX     = 2'd0,
    REG_RX     = 2'd1,
    REG_CTRL   = 2'd2,
    REG_HIDDEN = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2c_bp_txhold.sv
module i2c_bp_txhold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_tx,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  input  logic          lsb_first,
  output logic [DW-1:0] hold_q,
  output logic          tx_empty,
  output logic [DW-1:0] view
);
  logic [DW-1:0] hold_d;
  logic          empty_d, empty_q;
  logic [DW-1:0] rev;

  // mirror image of the held byte for the reversed register view
  for (genvar g = 0; g < DW; g++) begin : g_rev
    assign rev[g] = hold_q[DW-1-g];
  end

  always_comb begin
    hold_d  = hold_q;
    empty_d = empty_q;
    if (take)  empty_d = 1'b1;
    if (wr_tx) begin
      hold_d  = wdata;
      empty_d = 1'b0;   // a fresh write wins over a same-cycle take
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '1;
      empty_q <= 1'b1;
    end else begin
      hold_q  <= hold_d;
      empty_q <= empty_d;
    end
  end

  assign tx_empty = empty_q;
  assign view     = lsb_first ? rev : hold_q;
endmodule

// File: rtl/i2c_bp_shifter.sv
module i2c_bp_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_rx,
  input  logic          lsb_first,
  input  logic          shift_strobe,
  input  logic          sample_strobe,
  input  logic          sda_in,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_data,
  output logic          take,
  output logic          sda_out,
  output logic          rx_done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] sh_q, sh_d, rx_in;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          last, tx_step, rx_step;

  assign last    = (cnt_q == LAST);
  assign tx_step = !mode_rx && busy_q && shift_strobe;
  assign rx_step = mode_rx && sample_strobe;
  assign take    = !mode_rx && tx_avail && (!busy_q || (shift_strobe && last));
  assign rx_in   = lsb_first ? {sda_in, sh_q[DW-1:1]} : {sh_q[DW-2:0], sda_in};
  assign rx_done = rx_step && last;
  assign rx_byte = rx_in;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (take) begin
      sh_d   = tx_data;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (tx_step) begin
      sh_d   = lsb_first ? (sh_q >> 1) : (sh_q << 1);
      cnt_d  = last ? '0 : cnt_q + 1'b1;
      busy_d = !last;
    end else if (rx_step) begin
      sh_d   = rx_in;
      cnt_d  = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign sda_out = busy_q ? (lsb_first ? sh_q[0] : sh_q[DW-1]) : 1'b1;
endmodule

// File: rtl/i2c_bp_rxhold.sv
module i2c_bp_rxhold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          rd_rx,
  output logic [DW-1:0] rx_q,
  output logic          rx_full,
  output logic          rx_overrun
);
  logic [DW-1:0] rx_d;
  logic          full_d, full_q, ovr_d, ovr_q;

  always_comb begin
    rx_d   = rx_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    if (rd_rx) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (rx_done) begin
      if (full_q && !rd_rx) begin
        ovr_d = 1'b1;       // keep the unread byte
      end else begin
        rx_d   = rx_byte;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '1;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      rx_q   <= rx_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rx_full    = full_q;
  assign rx_overrun = ovr_q;
endmodule

// File: rtl/i2c_byte_path.sv
module i2c_byte_path
  import i2c_bp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          mode_rx,
  input  logic          shift_strobe,
  input  logic          sample_strobe,
  input  logic          sda_in,
  output logic          sda_out,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_overrun
);
  reg_sel_e      sel;
  logic          wr_tx, wr_ctrl, rd_rx;
  logic          lsb_q, lsb_d;
  logic          tx_take, rx_done;
  logic [DW-1:0] hold_q, tx_view, rx_byte, rx_q;

  assign sel     = reg_sel_e'(addr);
  assign wr_tx   = wr_en && (sel == REG_TX);
  assign wr_ctrl = wr_en && (sel == REG_CTRL);
  assign rd_rx   = rd_en && (sel == REG_RX);

  always_comb begin
    lsb_d = lsb_q;
    if (wr_ctrl) lsb_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lsb_q <= 1'b0;
    else        lsb_q <= lsb_d;
  end

  i2c_bp_txhold #(.DW(DW)) u_txh (
    .clk(clk), .rst_n(rst_n), .wr_tx(wr_tx), .wdata(wdata), .take(tx_take),
    .lsb_first(lsb_q), .hold_q(hold_q), .tx_empty(tx_empty), .view(tx_view)
  );

  i2c_bp_shifter #(.DW(DW)) u_sh (
    .clk(clk), .rst_n(rst_n), .mode_rx(mode_rx), .lsb_first(lsb_q),
    .shift_strobe(shift_strobe), .sample_strobe(sample_strobe), .sda_in(sda_in),
    .tx_avail(!tx_empty), .tx_data(hold_q), .take(tx_take), .sda_out(sda_out),
    .rx_done(rx_done), .rx_byte(rx_byte)
  );

  i2c_bp_rxhold #(.DW(DW)) u_rxh (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte), .rd_rx(rd_rx),
    .rx_q(rx_q), .rx_full(rx_full), .rx_overrun(rx_overrun)
  );

  always_comb begin
    unique case (sel)
      REG_TX:   rdata = tx_view;
      REG_RX:   rdata = rx_q;
      REG_CTRL: rdata = {{(DW-1){1'b0}}, lsb_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_byte_path_chk.sv
module i2c_byte_path_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [1:0]    addr,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          rx_overrun,
  input logic          take,
  input logic          rx_done,
  input logic [DW-1:0] rx_q
);
  logic wtx, rrx, wrx;
  assign wtx = wr_en && (addr == 2'd0);
  assign wrx = wr_en && (addr == 2'd1);
  assign rrx = rd_en && (addr == 2'd1);

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wtx |=> !tx_empty); // R2
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wtx) |=> tx_empty); // R2
  AST_DONE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_full); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rrx && !rx_done) |=> (!rx_full && !rx_overrun)); // R6
  AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !rrx) |=> (rx_overrun && $stable(rx_q))); // R7
  AST_RX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrx && !rx_done) |=> $stable(rx_q)); // R8
endmodule

bind i2c_byte_path i2c_byte_path_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .tx_empty(tx_empty), .rx_full(rx_full), .rx_overrun(rx_overrun),
  .take(tx_take), .rx_done(rx_done), .rx_q(rx_q)
);

// File: tb/sim_i2c_byte_path.sv
module sim_i2c_byte_path;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          mode_rx = 1'b0, shift_strobe = 1'b0, sample_strobe = 1'b0, sda_in = 1'b1;
  logic          sda_out, tx_empty, rx_full, rx_overrun;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_byte_path #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mode_rx(mode_rx), .shift_strobe(shift_strobe),
    .sample_strobe(sample_strobe), .sda_in(sda_in), .sda_out(sda_out),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_overrun(rx_overrun)
  );

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
    for (int i = 0; i < DW; i++) flip[i] = v[DW-1-i];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input bit clr, output logic [DW-1:0] d);
    addr = a; rd_en = clr;
    #1 d = rdata;
    step();
    rd_en = 1'b0;
  endtask

  function automatic logic tx_bit(input logic [DW-1:0] b, input int i, input bit lsb);
    return lsb ? b[i] : b[DW-1-i];
  endfunction

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rx_full", rx_full, 0);
    check("R1 rx_overrun", rx_overrun, 0);
    check("R1 sda_out", sda_out, 1);
    reg_rd(2'd0, 0, d); check("R1 tx reg", d, 8'hFF);
    reg_rd(2'd1, 0, d); check("R1 rx reg", d, 8'hFF);
  endtask

  task automatic t_tx_single(input logic [DW-1:0] b, input bit lsb);
    mode_rx = 1'b0;
    reg_wr(2'd2, {7'd0, lsb});
    reg_wr(2'd0, b);
    check("R2 empty cleared", tx_empty, 0);
    step();
    check("R2 empty after load", tx_empty, 1);
    for (int i = 0; i < DW; i++) begin
      check(lsb ? "R3 lsb-first bit" : "R3 msb-first bit", sda_out, tx_bit(b, i, lsb));
      shift_strobe = 1'b1; step(); shift_strobe = 1'b0;
    end
    check("R4 idle after byte", sda_out, 1);
  endtask

  task automatic t_tx_b2b(input logic [DW-1:0] a, input logic [DW-1:0] b);
    mode_rx = 1'b0;
    reg_wr(2'd2, 8'd0);
    reg_wr(2'd0, a);
    step();
    reg_wr(2'd0, b);
    check("R4 queued not empty", tx_empty, 0);
    for (int i = 0; i < 2*DW; i++) begin
      check("R4 continuous bit", sda_out, (i < DW) ? tx_bit(a, i, 0) : tx_bit(b, i-DW, 0));
      if (i == DW) check("R4 reload emptied", tx_empty, 1);
      shift_strobe = 1'b1; step(); shift_strobe = 1'b0;
    end
    check("R4 idle after pair", sda_out, 1);
  endtask

  task automatic rx_byte(input logic [DW-1:0] b, input bit lsb);
    mode_rx = 1'b1;
    for (int i = 0; i < DW; i++) begin
      sda_in = tx_bit(b, i, lsb);
      sample_strobe = 1'b1; step(); sample_strobe = 1'b0;
    end
    sda_in = 1'b1;
  endtask

  task automatic t_rx(input logic [DW-1:0] b, input bit lsb);
    logic [DW-1:0] d;
    reg_wr(2'd2, {7'd0, lsb});
    rx_byte(b, lsb);
    check("R5 rx_full set", rx_full, 1);
    reg_rd(2'd1, 1, d);
    check(lsb ? "R5 lsb-first byte" : "R5 msb-first byte", d, b);
    check("R6 rx_full cleared", rx_full, 0);
  endtask

  task automatic t_overrun();
    logic [DW-1:0] d;
    reg_wr(2'd2, 8'd0);
    rx_byte(8'h3C, 0);
    rx_byte(8'h81, 0);
    check("R7 overrun flag", rx_overrun, 1);
    reg_rd(2'd1, 1, d);
    check("R7 older byte kept", d, 8'h3C);
    check("R6 overrun cleared", rx_overrun, 0);
    check("R6 full cleared", rx_full, 0);
  endtask

  task automatic t_rx_nowrite();
    logic [DW-1:0] d;
    reg_wr(2'd2, 8'd0);
    rx_byte(8'h96, 0);
    reg_wr(2'd1, 8'h00);
    reg_rd(2'd1, 1, d);
    check("R8 rx write ignored", d, 8'h96);
  endtask

  task automatic t_view();
    logic [DW-1:0] d;
    mode_rx = 1'b0;
    reg_wr(2'd2, 8'd1);
    reg_wr(2'd0, 8'hC5);
    reg_rd(2'd0, 0, d); check("R9 reversed view", d, flip(8'hC5));
    reg_rd(2'd2, 0, d); check("R10 ctrl read lsb", d, 8'h01);
    reg_rd(2'd3, 0, d); check("R10 hidden reads zero", d, 8'h00);
    reg_wr(2'd2, 8'd0);
    reg_rd(2'd0, 0, d); check("R9 plain view", d, 8'hC5);
    reg_rd(2'd2, 0, d); check("R10 ctrl read msb", d, 8'h00);
    for (int i = 0; i < DW; i++) begin
      shift_strobe = 1'b1; step(); shift_strobe = 1'b0;
    end
    check("R4 drained", sda_out, 1);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step();
    t_reset();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_tx_single(8'hC5, 0);
    t_tx_single(8'h1E, 1);
    t_tx_b2b(8'hA7, 8'h4D);
    t_rx(8'hC5, 0);
    t_rx(8'h1E, 1);
    t_overrun();
    t_rx_nowrite();
    t_view();
    finish_run();
  end
endmodule